// File: doc/BRIEF.md
# Undersampled IF Downconverter

This block turns a stream of real 16-bit converter samples into a complex baseband stream. The samples come from a 60 MHz IF carrier taken at 50 MHz, below the carrier's Nyquist rate. The carrier therefore lands on exactly one fifth of the sample rate (10 MHz). It lands there without spectral inversion, because 60 MHz lies between 50 and 75 MHz. The echo on the carrier is about 3 MHz wide.

Since the alias is an exact fifth of the sample rate, the local oscillator is a fixed five-step cosine and negative-sine sequence. There is no phase accumulator. Each accepted sample is multiplied by the current step for I and for Q. Each product stream then passes through a second-order integrate-and-comb filter that decimates by five. The result is rounded and saturated back to 16 bits, giving a 10 MS/s complex output.

Both edges of the block are valid/ready streams. An input sample moves when `in_valid` and `in_ready` are both high at a rising edge. An output pair moves when `out_valid` and `out_ready` are both high. `in_ready` depends combinationally on `out_ready`. It drops only for the fifth sample of a group, and only while the previous result is still in the pipeline or is held on the output and not taken this cycle. The first four samples of every group are always accepted. A held output pair stays frozen until it is taken.

Top module: `alias_ddc`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `out_valid` to 0 and sets `in_ready` to 1. It also returns the oscillator to step 0, even partway through a group, so the next accepted sample after reset is mixed with step 0.
- R2: Accepted sample n (counted since reset) is multiplied by round(16384·cos(2πn/5)) for I and by round(−16384·sin(2πn/5)) for Q. The step-0 coefficients are +16384 and 0.
- R3: Each output value is round-half-up(S / 2^18), where S is the second-order comb/integrator sum with gain 25. For an input tone A·cos(2πn/5+φ), every output from the second one after reset onward is within ±2 of I = A·cosφ·25/32 and Q = A·sinφ·25/32.
- R4: A constant input level gives I = 0 and Q = 0 exactly, from the second output onward.
- R5: A result above +32767 leaves as +32767 (0x7FFF). A result below −32768 leaves as −32768 (0x8000).
- R6: Exactly one output pair is produced for every five accepted samples. Cycles with `in_valid` low neither feed the filter nor advance the oscillator, whatever `in_sample` holds.
- R7: `out_valid` goes high at the fourth rising edge after the edge that accepts the fifth sample of a group.
- R8: While `out_valid` is high and `out_ready` is low, `out_i`/`out_q` hold their values and no result is lost. During that time `in_ready` is low only for a group's fifth sample, and it returns high in the cycle `out_ready` rises.
- R9: With `in_valid` and `out_ready` held high, `in_ready` stays high and one sample is taken every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block takes the offered sample at this edge |
| in_sample | input | 16 | Real two's-complement converter sample |
| out_valid | output | 1 | Output pair held and offered |
| out_ready | input | 1 | Consumer takes the pair at this edge |
| out_i | output | 16 | In-phase baseband value, two's complement |
| out_q | output | 16 | Quadrature baseband value, two's complement |

## Verification
A group's result reaches the output register four rising edges after the edge that accepts its fifth sample. The bench counts falling edges from that accepting edge and expects `out_valid` at the fifth one. The filter needs one full group before it settles, so tone, level and saturation results are compared from the second output pair onward, and every output pair is captured on a falling edge while a transfer is pending. During back-pressure the held pair and `in_ready` are sampled on each falling edge, and the `in_ready` response to `out_ready` is sampled in the same cycle.

// File: rtl/alias_ddc_pkg.sv
`timescale 1ns/1ps
package alias_ddc_pkg;

  // Oscillator period in samples: the carrier aliases to fs/5.
  localparam int LO_LEN    = 5;
  localparam int LO_PH_W   = $clog2(LO_LEN);
  localparam int COEF_W    = 16;
  localparam int COEF_FRAC = 14;
  localparam int N_CH      = 2;

  typedef logic signed [COEF_W-1:0] coef_t;
  typedef logic [LO_PH_W-1:0]       lo_ph_t;

  typedef struct packed {
    coef_t cos_c;
    coef_t nsin_c;
  } lo_pair_t;

  // cos and -sin of 2*pi*k/5, scaled by 2^COEF_FRAC and rounded.
  function automatic lo_pair_t lo_lookup(input lo_ph_t ph);
    lo_pair_t p;
    case (ph)
      lo_ph_t'(0): p = '{cos_c:  16'sd16384, nsin_c:  16'sd0};
      lo_ph_t'(1): p = '{cos_c:  16'sd5063,  nsin_c: -16'sd15582};
      lo_ph_t'(2): p = '{cos_c: -16'sd13255, nsin_c: -16'sd9630};
      lo_ph_t'(3): p = '{cos_c: -16'sd13255, nsin_c:  16'sd9630};
      lo_ph_t'(4): p = '{cos_c:  16'sd5063,  nsin_c:  16'sd15582};
      default:     p = '{cos_c:  16'sd0,     nsin_c:  16'sd0};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/alias_ddc_lo.sv
`timescale 1ns/1ps
module alias_ddc_lo
  import alias_ddc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     step,
  output lo_pair_t coef
);

  lo_ph_t phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (step) begin
      phase_q <= (phase_q == lo_ph_t'(LO_LEN - 1)) ? '0 : phase_q + 1'b1;
    end
  end

  assign coef = lo_lookup(phase_q);

  AST_LO_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    phase_q < lo_ph_t'(LO_LEN)) else $error("oscillator step out of range"); // R2

  AST_LO_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(phase_q)) else $error("oscillator moved without a sample"); // R6

endmodule

// File: rtl/alias_ddc_mix.sv
`timescale 1ns/1ps
module alias_ddc_mix
  import alias_ddc_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int PROD_W = IN_W + COEF_W
)(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fire,
  input  logic                     grp_last,
  input  logic signed [IN_W-1:0]   sample,
  input  coef_t                    coef,
  output logic signed [PROD_W-1:0] prod,
  output logic                     prod_vld,
  output logic                     prod_last
);

  logic signed [PROD_W-1:0] prod_d;

  assign prod_d = sample * coef;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod      <= '0;
      prod_vld  <= 1'b0;
      prod_last <= 1'b0;
    end else begin
      prod_vld  <= fire;
      prod_last <= fire && grp_last;
      if (fire) begin
        prod <= prod_d;
      end
    end
  end

endmodule

// File: rtl/alias_ddc_cic2.sv
`timescale 1ns/1ps
module alias_ddc_cic2 #(
  parameter int PROD_W = 32,
  parameter int ACC_W  = 38
)(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     prod_vld,
  input  logic                     prod_last,
  input  logic signed [PROD_W-1:0] prod,
  output logic signed [ACC_W-1:0]  res,
  output logic                     res_vld
);

  localparam int EXT_W = ACC_W - PROD_W;

  logic signed [ACC_W-1:0] integ1, integ2;
  logic signed [ACC_W-1:0] integ2_dly, comb1_dly;
  logic signed [ACC_W-1:0] comb1;
  logic signed [ACC_W-1:0] prod_ext;
  logic                    s1_vld, s1_last, s2_last;

  assign prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};
  assign comb1    = integ2 - integ2_dly;

  // Integrators run at the input rate and may wrap; the combs undo the wrap.
  always_ff @(posedge clk) begin
    if (rst) begin
      integ1     <= '0;
      integ2     <= '0;
      integ2_dly <= '0;
      comb1_dly  <= '0;
      res        <= '0;
      res_vld    <= 1'b0;
      s1_vld     <= 1'b0;
      s1_last    <= 1'b0;
      s2_last    <= 1'b0;
    end else begin
      s1_vld  <= prod_vld;
      s1_last <= prod_vld && prod_last;
      if (prod_vld) begin
        integ1 <= integ1 + prod_ext;
      end
      s2_last <= s1_vld && s1_last;
      if (s1_vld) begin
        integ2 <= integ2 + integ1;
      end
      res_vld <= s2_last;
      if (s2_last) begin
        integ2_dly <= integ2;
        comb1_dly  <= comb1;
        res        <= comb1 - comb1_dly;
      end
    end
  end

  AST_CIC_SPACED: assert property (@(posedge clk) disable iff (rst)
    res_vld |=> !res_vld) else $error("decimated results back to back"); // R6

endmodule

// File: rtl/alias_ddc_out.sv
`timescale 1ns/1ps
module alias_ddc_out #(
  parameter int ACC_W     = 38,
  parameter int OUT_W     = 16,
  parameter int OUT_SHIFT = 18
)(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    res_vld,
  input  logic signed [ACC_W-1:0] res_i,
  input  logic signed [ACC_W-1:0] res_q,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [OUT_W-1:0]        out_i,
  output logic [OUT_W-1:0]        out_q
);

  localparam logic signed [ACC_W-1:0] RND_K =
    {{(ACC_W-1){1'b0}}, 1'b1} << (OUT_SHIFT - 1);
  localparam logic signed [ACC_W-1:0] MAX_V =
    {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MIN_V =
    {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  function automatic logic [OUT_W-1:0] shape(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W-1:0] r;
    r = (a + RND_K) >>> OUT_SHIFT;
    if (r > MAX_V)      return MAX_V[OUT_W-1:0];
    else if (r < MIN_V) return MIN_V[OUT_W-1:0];
    else                return r[OUT_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else if (res_vld) begin
      out_valid <= 1'b1;
      out_i     <= shape(res_i);
      out_q     <= shape(res_q);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> !(out_valid && !out_ready)) else $error("held pair overwritten"); // R8

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_i) && $stable(out_q))
    else $error("held pair changed"); // R8

endmodule

// File: rtl/alias_ddc.sv
`timescale 1ns/1ps
module alias_ddc
  import alias_ddc_pkg::*;
#(
  parameter int IN_W      = 16,
  parameter int OUT_W     = 16,
  parameter int DECIM     = 5,
  parameter int OUT_SHIFT = 18
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_sample,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_i,
  output logic [OUT_W-1:0] out_q
);

  localparam int CNT_W  = $clog2(DECIM);
  localparam int PROD_W = IN_W + COEF_W;
  localparam int ACC_W  = PROD_W + 2 * CNT_W;

  logic [CNT_W-1:0] grp_cnt;
  logic             grp_last;
  logic             accept;
  logic             inflight;
  lo_pair_t         lo_c;

  logic signed [ACC_W-1:0] res_ch [N_CH];
  logic [N_CH-1:0]         res_vld_ch;
  logic                    res_vld;

  assign grp_last = (grp_cnt == CNT_W'(DECIM - 1));
  // Only a group's closing sample may wait: it is the one that creates a result.
  assign in_ready = !grp_last || (!inflight && (!out_valid || out_ready));
  assign accept   = in_valid && in_ready;
  assign res_vld  = &res_vld_ch;

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_cnt  <= '0;
      inflight <= 1'b0;
    end else begin
      if (accept) begin
        grp_cnt <= grp_last ? '0 : grp_cnt + 1'b1;
      end
      if (accept && grp_last) begin
        inflight <= 1'b1;
      end else if (res_vld) begin
        inflight <= 1'b0;
      end
    end
  end

  alias_ddc_lo i_lo (
    .clk  (clk),
    .rst  (rst),
    .step (accept),
    .coef (lo_c)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    coef_t                    c_sel;
    logic signed [PROD_W-1:0] prod;
    logic                     prod_vld;
    logic                     prod_last;

    assign c_sel = (g == 0) ? lo_c.cos_c : lo_c.nsin_c;

    alias_ddc_mix #(.IN_W(IN_W), .PROD_W(PROD_W)) i_mix (
      .clk       (clk),
      .rst       (rst),
      .fire      (accept),
      .grp_last  (grp_last),
      .sample    ($signed(in_sample)),
      .coef      (c_sel),
      .prod      (prod),
      .prod_vld  (prod_vld),
      .prod_last (prod_last)
    );

    alias_ddc_cic2 #(.PROD_W(PROD_W), .ACC_W(ACC_W)) i_cic (
      .clk       (clk),
      .rst       (rst),
      .prod_vld  (prod_vld),
      .prod_last (prod_last),
      .prod      (prod),
      .res       (res_ch[g]),
      .res_vld   (res_vld_ch[g])
    );
  end

  alias_ddc_out #(.ACC_W(ACC_W), .OUT_W(OUT_W), .OUT_SHIFT(OUT_SHIFT)) i_out (
    .clk       (clk),
    .rst       (rst),
    .res_vld   (res_vld),
    .res_i     (res_ch[0]),
    .res_q     (res_ch[1]),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
  );

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid && in_ready) else $error("not idle after reset"); // R1

  AST_STALL_ONLY_LAST: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> grp_last && (inflight || out_valid)) else $error("early sample stalled"); // R8

endmodule

// File: tb/test_alias_ddc.sv
`timescale 1ns/1ps
module test_alias_ddc;

  localparam int TOL = 2;
  localparam int NV  = 6;
  // amplitude, phase in degrees, expected I, expected Q (R3)
  localparam int VEC [NV][4] = '{
    '{16384,   0,  12800,      0},
    '{16384,  90,      0,  12800},
    '{ 8192, 180,  -6400,      0},
    '{20000, 270,      0, -15625},
    '{16384,  45,   9051,   9051},
    '{    0,   0,      0,      0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        out_ready = 1'b1;
  logic [15:0] in_sample = '0;
  logic        in_ready, out_valid;
  logic [15:0] out_i, out_q;

  int n_chk = 0;
  int n_bad = 0;
  int cap_n = 0;
  int cap_i [64];
  int cap_q [64];

  alias_ddc i_alias_ddc (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_sample (in_sample),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_i     (out_i),
    .out_q     (out_q)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (cap_n < 64) begin
        cap_i[cap_n] = int'($signed(out_i));
        cap_q[cap_n] = int'($signed(out_q));
      end
      cap_n = cap_n + 1;
    end
  end

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int iabs(input int x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic int tone(input int amp, input int deg, input int n);
    real ph, v;
    ph = 2.0 * 3.14159265358979 * n / 5.0 + deg * 3.14159265358979 / 180.0;
    v  = amp * $cos(ph);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic do_reset;
    rst = 1'b1;
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    cap_n = 0;
    rst = 1'b0;
  endtask

  task automatic push(input int x);
    in_valid  = 1'b1;
    in_sample = 16'(x);
    do @(negedge clk); while (!in_ready);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic drain;
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic check_steady(input string req, input int ei, input int eq, input int tol);
    for (int k = 1; k < cap_n && k < 64; k++) begin
      chk(iabs(cap_i[k] - ei) <= tol, {req, " I"}, cap_i[k], ei);
      chk(iabs(cap_q[k] - eq) <= tol, {req, " Q"}, cap_q[k], eq);
    end
  endtask

  initial begin
    // R1: reset state
    do_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    // Vector table: tones at the alias frequency (R2, R3, R6)
    for (int v = 0; v < NV; v++) begin
      do_reset();
      for (int n = 0; n < 30; n++) push(tone(VEC[v][0], VEC[v][1], n));
      drain();
      chk(cap_n == 6, "R6 output count", cap_n, 6);
      check_steady("R2,R3 tone", VEC[v][2], VEC[v][3], TOL);
    end

    // R1: reset partway through a group restarts the oscillator
    do_reset();
    for (int n = 0; n < 3; n++) push(30000);
    do_reset();
    for (int n = 0; n < 30; n++) push(tone(16384, 90, n));
    drain();
    chk(cap_n == 6, "R1 count after mid-group reset", cap_n, 6);
    check_steady("R1 phase restart", 0, 12800, TOL);

    // R4: constant level is rejected exactly
    do_reset();
    for (int n = 0; n < 25; n++) push(12345);
    drain();
    chk(cap_n == 5, "R4 output count", cap_n, 5);
    check_steady("R4 level", 0, 0, 0);

    // R5: positive saturation
    do_reset();
    for (int n = 0; n < 30; n++) push((n % 5 == 2 || n % 5 == 3) ? -32767 : 32767);
    drain();
    check_steady("R5 high clamp", 32767, 0, 0);

    // R5: negative saturation
    do_reset();
    for (int n = 0; n < 30; n++) push((n % 5 == 2 || n % 5 == 3) ? 32767 : -32767);
    drain();
    check_steady("R5 low clamp", -32768, 0, 0);

    // R6: idle cycles with junk data are ignored
    do_reset();
    for (int n = 0; n < 30; n++) begin
      in_valid  = 1'b0;
      in_sample = 16'h5A5A ^ 16'(n * 977);
      repeat (n % 3) begin
        @(posedge clk);
        #1;
      end
      push(tone(16384, 0, n));
    end
    drain();
    chk(cap_n == 6, "R6 count with gaps", cap_n, 6);
    check_steady("R6 gaps", 12800, 0, TOL);

    // R7: output latency from the accepting edge of the fifth sample
    do_reset();
    for (int n = 0; n < 4; n++) push(tone(16384, 0, n));
    begin
      int seen;
      seen = 0;
      push(tone(16384, 0, 4));
      for (int k = 1; k <= 7; k++) begin
        @(negedge clk);
        if (out_valid && seen == 0) seen = k;
      end
      chk(seen == 5, "R7 out_valid falling-edge index", seen, 5);
    end

    // R8: back-pressure holds the pair and stalls only the closing sample
    do_reset();
    out_ready = 1'b0;
    for (int n = 0; n < 9; n++) push(tone(16384, 0, n));
    begin
      logic [15:0] hi, hq;
      bit held_ok;
      in_valid  = 1'b1;
      in_sample = 16'(tone(16384, 0, 9));
      @(negedge clk);
      hi = out_i;
      hq = out_q;
      chk(out_valid == 1'b1, "R8 pair offered", int'(out_valid), 1);
      held_ok = 1'b1;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (in_ready || !out_valid || out_i != hi || out_q != hq) held_ok = 1'b0;
      end
      chk(held_ok, "R8 hold and stall", int'(held_ok), 1);
      chk(cap_n == 0, "R8 nothing transferred while blocked", cap_n, 0);
      @(posedge clk);
      #1;
      out_ready = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1, "R8 release same cycle", int'(in_ready), 1);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      for (int n = 10; n < 30; n++) push(tone(16384, 0, n));
      drain();
      chk(cap_n == 6, "R8 no result lost", cap_n, 6);
      chk(cap_i[0] == int'($signed(hi)), "R8 held pair delivered", cap_i[0], int'($signed(hi)));
      check_steady("R8 values after stall", 12800, 0, TOL);
    end

    // R9: full-rate streaming never stalls
    do_reset();
    begin
      int stalls;
      stalls = 0;
      for (int n = 0; n < 50; n++) begin
        in_valid  = 1'b1;
        in_sample = 16'(tone(8192, 180, n));
        @(negedge clk);
        if (!in_ready) stalls++;
        @(posedge clk);
        #1;
      end
      in_valid = 1'b0;
      drain();
      chk(stalls == 0, "R9 stall cycles", stalls, 0);
      chk(cap_n == 10, "R6 count at full rate", cap_n, 10);
      check_steady("R9 values at full rate", -6400, 0, TOL);
    end

    finish_run();
  end

endmodule